// File: doc/BRIEF.md
# Two-Wire Serial Command Decoder for Parallel SRAM

This block lets a controller with only two spare lines, a shift clock and one data bit, address a parallel static RAM and choose between a write and a read. The shift clock is the block's clock: every rising edge takes one bit from the data line. A frame has two fields. The first is an address field of fifteen bits: two zero pad bits, then the thirteen address bits, most significant first. The second is a command field of fifteen bits: fourteen ones, then one operation bit.

The pad bits keep the address field from ever holding fourteen ones in a row. A long run of ones can therefore only mean a command, and a short command pattern, which any address could contain by chance, is never needed. When the operation bit is taken, the address outputs load the new address and exactly one active-low strobe pulses for one clock period. The strobe is the write strobe or the output enable. The address outputs are held in a register, so they stay still while later bits shift in. The eight-bit data path of the RAM is handled elsewhere.

Top module: `sram_serial_ctl`

## Requirements
- R1: While synchronous reset `rst` is high at a clock edge, that edge sets `ram_addr` to zero and sets both `ram_we_n` and `ram_oe_n` high. The first bit taken after reset is the first bit of an address field.
- R2: A frame is two fields. The address field is fifteen bits: two pad bits, then the address, most significant bit first. The command field is fourteen ones followed by one operation bit. At the edge that takes the operation bit of a valid frame, `ram_addr` takes the thirteen address bits.
- R3: `ram_addr` changes only at the edge that takes the operation bit of a valid frame. It holds its value during all other shifting.
- R4: An operation bit of 1 drives `ram_we_n` low, and 0 drives `ram_oe_n` low. The strobe goes low for exactly the one clock period after the capture edge, then returns high.
- R5: `ram_we_n` and `ram_oe_n` are never low in the same cycle.
- R6: A zero among the first fourteen bits of the command field ends the frame. No strobe is asserted, `ram_addr` is left unchanged, and the next bit starts a new address field.
- R7: If either pad bit is 1, the frame is rejected. Its command field is still consumed, but no strobe is asserted and `ram_addr` is left unchanged.
- R8: The bit after an operation bit starts the next address field. Back-to-back frames each give their own update and strobe.
- R9: Addresses with long runs of ones, including all ones (0x1FFF) and values ending in ones, are decoded correctly. Ones at the end of the address field are never counted as command bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; one serial bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdat | input | 1 | Serial data bit |
| ram_addr | output | 13 | Registered RAM address |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |

## Verification
Frames are sent with a mixed address, with all ones, and with trailing ones. This separates true framing from a plain ones counter, which would misplace the operation bit when address ones run into the command. A command cut short by a zero and a frame with a set pad bit each separate a real rejection from a silent update. A long back-to-back run of pseudo-random frames, mixing reads and writes, shows that alignment holds across frames. A reference model in the bench predicts the address and both strobes on every clock.

// File: rtl/srcd_pkg.sv
package srcd_pkg;

    localparam int unsigned ADDR_W_DEF  = 13;
    localparam int unsigned PAD_W_DEF   = 2;
    localparam int unsigned RUN_LEN_DEF = 14;

    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_CMD  = 1'b1
    } phase_e;

    // Per-bit events produced by the framer for the datapath.
    typedef struct packed {
        logic start;    // bit is the first of an address field
        logic pad_hit;  // bit is a pad position and is set
        logic shift;    // bit is an address bit
        logic fire;     // bit is the operation bit
        logic wr;       // operation requested (valid with fire)
    } frame_ev_t;

    function automatic int unsigned cnt_w(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/srcd_framer.sv
module srcd_framer
    import srcd_pkg::*;
#(
    parameter int unsigned ADDR_W  = ADDR_W_DEF,
    parameter int unsigned PAD_W   = PAD_W_DEF,
    parameter int unsigned RUN_LEN = RUN_LEN_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sdat,
    output frame_ev_t ev
);
    localparam int unsigned FIELD_W = ADDR_W + PAD_W;
    localparam int unsigned BW      = cnt_w(FIELD_W);
    localparam int unsigned RW      = cnt_w(RUN_LEN + 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(FIELD_W - 1);
    localparam logic [BW-1:0] PAD_END  = BW'(PAD_W);
    localparam logic [RW-1:0] RUN_FULL = RW'(RUN_LEN);

    phase_e        phase_q;
    logic [BW-1:0] bit_q;
    logic [RW-1:0] run_q;

    always_comb begin
        ev         = '0;
        ev.start   = (phase_q == PH_ADDR) && (bit_q == '0);
        ev.pad_hit = (phase_q == PH_ADDR) && (bit_q < PAD_END) && sdat;
        ev.shift   = (phase_q == PH_ADDR) && (bit_q >= PAD_END);
        ev.fire    = (phase_q == PH_CMD) && (run_q == RUN_FULL);
        ev.wr      = sdat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ADDR;
            bit_q   <= '0;
            run_q   <= '0;
        end else if (phase_q == PH_ADDR) begin
            if (bit_q == BIT_LAST) begin
                phase_q <= PH_CMD;
                bit_q   <= '0;
                run_q   <= '0;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end else begin
            if (run_q == RUN_FULL) begin
                phase_q <= PH_ADDR;          // operation bit consumed
                run_q   <= '0;
            end else if (sdat) begin
                run_q <= run_q + 1'b1;
            end else begin
                phase_q <= PH_ADDR;          // broken run: restart framing
                run_q   <= '0;
            end
        end
    end

    p_abort_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CMD && !sdat && run_q != RUN_FULL) |=> (phase_q == PH_ADDR && bit_q == '0));

    p_fire_returns_r8: assert property (@(posedge clk) disable iff (rst)
        ev.fire |=> (phase_q == PH_ADDR && bit_q == '0));

endmodule

// File: rtl/srcd_addr_path.sv
module srcd_addr_path
    import srcd_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdat,
    input  frame_ev_t         ev,
    output logic [ADDR_W-1:0] addr_q,
    output logic              accept
);
    logic [ADDR_W-1:0] sreg_q;
    logic              pad_bad_q;

    assign accept = ev.fire && !pad_bad_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q    <= '0;
            pad_bad_q <= 1'b0;
            addr_q    <= '0;
        end else begin
            if (ev.shift)
                sreg_q <= {sreg_q[ADDR_W-2:0], sdat};
            if (ev.start)
                pad_bad_q <= ev.pad_hit;
            else if (ev.pad_hit)
                pad_bad_q <= 1'b1;
            if (accept)
                addr_q <= sreg_q;
        end
    end

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(addr_q));

    p_pad_reject_r7: assert property (@(posedge clk) disable iff (rst)
        (ev.fire && pad_bad_q) |=> $stable(addr_q));

endmodule

// File: rtl/srcd_strobe.sv
module srcd_strobe
    import srcd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic wr,
    output logic we_n,
    output logic oe_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            we_n <= 1'b1;
            oe_n <= 1'b1;
        end else begin
            we_n <= !(accept && wr);
            oe_n <= !(accept && !wr);
        end
    end

    p_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !oe_n));

    p_we_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (!we_n && !accept) |=> we_n);

    p_oe_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && !accept) |=> oe_n);

    p_we_follow_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && wr) |=> (!we_n && oe_n));

    p_oe_follow_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && !wr) |=> (!oe_n && we_n));

endmodule

// File: rtl/sram_serial_ctl.sv
module sram_serial_ctl
    import srcd_pkg::*;
#(
    parameter int unsigned ADDR_W  = ADDR_W_DEF,
    parameter int unsigned PAD_W   = PAD_W_DEF,
    parameter int unsigned RUN_LEN = RUN_LEN_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdat,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we_n,
    output logic              ram_oe_n
);
    // The command run must be longer than any run an address field can hold.
    initial begin
        a_run_len_ok_r2: assert (RUN_LEN > ADDR_W && ADDR_W > 1);
    end

    frame_ev_t ev;
    logic      accept;

    srcd_framer #(
        .ADDR_W (ADDR_W),
        .PAD_W  (PAD_W),
        .RUN_LEN(RUN_LEN)
    ) u_framer (
        .clk (clk),
        .rst (rst),
        .sdat(sdat),
        .ev  (ev)
    );

    srcd_addr_path #(
        .ADDR_W(ADDR_W)
    ) u_addr (
        .clk   (clk),
        .rst   (rst),
        .sdat  (sdat),
        .ev    (ev),
        .addr_q(ram_addr),
        .accept(accept)
    );

    srcd_strobe u_strobe (
        .clk   (clk),
        .rst   (rst),
        .accept(accept),
        .wr    (ev.wr),
        .we_n  (ram_we_n),
        .oe_n  (ram_oe_n)
    );

endmodule

// File: tb/sim_sram_serial_ctl.sv
module sim_sram_serial_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sdat = 1'b0;
    logic [AW-1:0] ram_addr;
    logic          ram_we_n, ram_oe_n;

    int checks = 0;
    int fails  = 0;
    int we_pulses = 0;
    int oe_pulses = 0;
    bit armed = 0;
    bit done  = 0;

    // reference model state
    int          m_pos = 0;
    int          m_acc = 0;
    bit          m_pad_bad = 0;
    logic [AW-1:0] exp_addr = '0;
    bit          exp_we = 1, exp_oe = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_serial_ctl u0 (
        .clk(clk), .rst(rst), .sdat(sdat),
        .ram_addr(ram_addr), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n)
    );

    // Behavioural frame model: 15 address-field bits, 14 run bits, 1 op bit.
    always @(posedge clk) begin
        exp_we = 1; exp_oe = 1;
        if (rst) begin
            m_pos = 0; m_acc = 0; m_pad_bad = 0; exp_addr = '0;
        end else if (m_pos < 15) begin
            if (m_pos < 2) begin
                if (m_pos == 0) m_pad_bad = 0;
                if (sdat) m_pad_bad = 1;
            end else begin
                m_acc = ((m_acc << 1) | int'(sdat)) & 32'h1FFF;
            end
            m_pos++;
        end else if (m_pos < 29) begin
            if (!sdat) m_pos = 0; else m_pos++;
        end else begin
            if (!m_pad_bad) begin
                exp_addr = m_acc[AW-1:0];
                if (sdat) exp_we = 0; else exp_oe = 0;
            end
            m_pos = 0;
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            checks++;
            if (ram_addr !== exp_addr) begin
                fails++;
                $display("FAIL R3 address: actual %h expected %h", ram_addr, exp_addr);
            end
            checks++;
            if (ram_we_n !== exp_we || ram_oe_n !== exp_oe) begin
                fails++;
                $display("FAIL R4 strobes we/oe: actual %b%b expected %b%b",
                         ram_we_n, ram_oe_n, exp_we, exp_oe);
            end
            checks++;
            if (!ram_we_n && !ram_oe_n) begin
                fails++;
                $display("FAIL R5 both strobes low: actual 00 expected not 00");
            end
            if (!ram_we_n) we_pulses++;
            if (!ram_oe_n) oe_pulses++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input bit b);
        sdat = b;
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic send_frame(input logic [AW-1:0] a, input bit op, input logic [1:0] pad);
        send_bit(pad[1]);
        send_bit(pad[0]);
        for (int i = AW - 1; i >= 0; i--) send_bit(a[i]);
        for (int i = 0; i < 14; i++) send_bit(1'b1);
        send_bit(op);
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        int w0, r0;
        int seed;
        logic [AW-1:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 addr after reset", int'(ram_addr), 0);
        check("R1 we_n after reset", int'(ram_we_n), 1);
        check("R1 oe_n after reset", int'(ram_oe_n), 1);
        rst = 1'b0;
        #1;
        armed = 1;

        // R2 / R4: write to a mixed address
        w0 = we_pulses;
        send_frame(13'h0A5C, 1'b1, 2'b00);
        check("R2 address latched", int'(ram_addr), 'h0A5C);
        check("R4 one write pulse", we_pulses - w0, 1);

        // R9 / R4: read at all-ones address
        r0 = oe_pulses;
        send_frame(13'h1FFF, 1'b0, 2'b00);
        check("R9 all-ones address", int'(ram_addr), 'h1FFF);
        check("R4 one read pulse", oe_pulses - r0, 1);

        // R9: trailing ones in the address
        send_frame(13'h00FF, 1'b1, 2'b00);
        check("R9 trailing-ones address", int'(ram_addr), 'h00FF);

        // R6: command run broken by a zero, then a new frame
        w0 = we_pulses; r0 = oe_pulses;
        send_bit(0); send_bit(0);
        for (int i = AW - 1; i >= 0; i--) send_bit(i[0]);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        send_bit(1'b0);
        check("R6 addr unchanged after abort", int'(ram_addr), 'h00FF);
        check("R6 no strobe after abort", (we_pulses - w0) + (oe_pulses - r0), 0);
        send_frame(13'h1234, 1'b0, 2'b00);
        check("R6 realigned frame", int'(ram_addr), 'h1234);

        // R7: set pad bit rejects the frame
        w0 = we_pulses; r0 = oe_pulses;
        send_frame(13'h0777, 1'b1, 2'b01);
        check("R7 addr unchanged on pad error", int'(ram_addr), 'h1234);
        check("R7 no strobe on pad error", (we_pulses - w0) + (oe_pulses - r0), 0);
        send_frame(13'h0333, 1'b1, 2'b10);
        check("R7 addr unchanged on first pad", int'(ram_addr), 'h1234);

        // R8: back-to-back frames with pseudo-random content
        seed = 32'h1ACE;
        w0 = we_pulses; r0 = oe_pulses;
        for (int k = 0; k < 40; k++) begin
            seed = seed * 1103515245 + 12345;
            held = seed[AW+7:8];
            send_frame(held, seed[3], 2'b00);
            check("R8 back-to-back address", int'(ram_addr), int'(held));
        end
        check("R8 total strobes", (we_pulses - w0) + (oe_pulses - r0), 40);

        // R3: address stays put while a later frame shifts in
        held = ram_addr;
        send_bit(0); send_bit(0);
        for (int i = 0; i < AW; i++) send_bit(~held[i]);
        check("R3 addr stable mid-frame", int'(ram_addr), int'(held));

        done = 1;
        report();
    end
endmodule